// File: doc/BRIEF.md
# Block-Move DMA Engine

This engine copies a run of 32-bit words between a local SRAM buffer and host memory, in either direction. Software programs a host word address, a local word address and a byte count through a 32-bit register port, then writes a command word to pick the direction. The engine then alternates reads on the source side with writes on the destination side. Each word moved advances both addresses by four and lowers the byte count by four. Software can poll the count until it reads zero, or it can wait for an interrupt.

One shared interrupt register carries two kinds of bits. The low three bits are enables, written directly. Bits 8 to 10 are status bits for completion, correctable error and abort, and each one clears when software writes a one to it. An abort can come from an error input during a transfer. It stops the engine and leaves the address, count and command registers as they were, so software can find how far the copy got.

Top module: `blkmove_dma`

## Requirements
- R1: After reset every register reads zero, `irq` is low and neither memory port makes a request.
- R2: The registers sit at byte offsets 0x60 (host address), 0x64 (local address), 0x68 (byte count, low 16 bits only), 0x6C (command) and 0x70 (interrupt). While the engine is idle each one reads back what was written to it.
- R3: Command value 1 copies words from local memory to host memory. The first word read is at the local address and is written at the host address. Each later word uses addresses 4 higher on both sides.
- R4: Command value 2 copies words in the other direction, from host memory to local memory, and advances the addresses in the same way.
- R5: Each word moved lowers the byte count by 4, and the count never goes below zero. A count that is not a multiple of 4 therefore moves ceil(count/4) words. At the end the count reads 0 and each address reads its start value plus 4 times the number of words.
- R6: Completion sets status bit 8. A move command given with a count of zero sets bit 8 at once, and neither memory port makes a request.
- R7: A write to 0x70 loads bits 2:0 as the enables. It clears each status bit in 10:8 whose written bit is 1 and leaves the other status bits unchanged.
- R8: `irq` is high when any of these holds: bit 8 and enable bit 0 are both set; bit 9 and enable bit 1 are both set; or bit 10 is set and enable bit 2 is clear.
- R9: When `abort_err` is high during a transfer, the engine stops and sets bit 10. The count, both addresses and the command register keep their values, so the count plus the distance the host address has advanced equals the count that was programmed.
- R10: While a transfer runs, a nonzero command write is ignored, and so are writes to the address and count registers. The transfer finishes in its original direction.
- R11: Writing 0 to the command register stops a running transfer at once and clears the command register. It sets no status bit, and the count stays frozen.
- R12: A pulse on `corr_err` sets status bit 9.
- R13: At most one memory port makes a request at any time, and a request stays high until its acknowledge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| loc_req | output | 1 | Local memory request |
| loc_we | output | 1 | Local request is a write |
| loc_addr | output | 32 | Local byte address |
| loc_wdata | output | 32 | Local write data |
| loc_ack | input | 1 | Local acknowledge; read data valid |
| loc_rdata | input | 32 | Local read data |
| host_req | output | 1 | Host memory request |
| host_we | output | 1 | Host request is a write |
| host_addr | output | 32 | Host byte address |
| host_wdata | output | 32 | Host write data |
| host_ack | input | 1 | Host acknowledge; read data valid |
| host_rdata | input | 32 | Host read data |
| abort_err | input | 1 | Transfer error; aborts a running move |
| corr_err | input | 1 | Correctable error event |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the memory ports: an acknowledge comes only while a request is high, it lasts a single cycle, and no acknowledge is already pending when a new request begins. The bench memory models meet this because each one raises its acknowledge exactly one cycle after it sees a request that has not yet been answered. The assertions also assume that software never writes a move command and a stop in the same cycle. The bench drives one register write per cycle pair, so this cannot happen. Random transfers keep both address windows inside the modelled memories, and they leave one sentinel word after each destination run so that a word written past the end would be seen.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_STORE} bm_state_e;
   localparam logic [7:0] OFS_HADDR = 8'h60;
   localparam logic [7:0] OFS_LADDR = 8'h64;
   localparam logic [7:0] OFS_COUNT = 8'h68;
   localparam logic [7:0] OFS_CMD   = 8'h6C;
   localparam logic [7:0] OFS_INT   = 8'h70;
   localparam logic [1:0] CMD_L2H   = 2'd1;
   localparam logic [1:0] CMD_H2L   = 2'd2;
endpackage

// File: rtl/bm_regs.sv
module bm_regs
   import blkmove_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [7:0]    reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          busy,
   input  logic          step,
   input  logic          fin,
   input  logic          abrt,
   input  logic          corr_err,
   output logic [AW-1:0] host_base,
   output logic [AW-1:0] loc_base,
   output logic [1:0]    cmd,
   output logic          start,
   output logic          stop,
   output logic          cnt_last,
   output logic          cnt_zero,
   output logic          irq
);
   localparam logic [CW-1:0] WORD_BYTES = CW'(4);

   logic [AW-1:0] host_q, loc_q;
   logic [CW-1:0] cnt_q;
   logic [1:0]    cmd_q;
   logic [2:0]    en_q, sts_q, clr;
   logic          wr_cmd, wr_int, go_ok;

   assign wr_cmd   = reg_wr && (reg_addr == OFS_CMD);
   assign wr_int   = reg_wr && (reg_addr == OFS_INT);
   assign go_ok    = (reg_wdata == DW'(CMD_L2H)) || (reg_wdata == DW'(CMD_H2L));
   assign start    = wr_cmd && !busy && go_ok;
   assign stop     = wr_cmd && (reg_wdata == '0);
   assign cnt_last = (cnt_q <= WORD_BYTES);
   assign cnt_zero = (cnt_q == '0);
   assign clr      = wr_int ? reg_wdata[10:8] : 3'b000;
   assign irq      = (sts_q[0] & en_q[0]) | (sts_q[1] & en_q[1]) | (sts_q[2] & ~en_q[2]);
   assign host_base = host_q;
   assign loc_base  = loc_q;
   assign cmd       = cmd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host_q <= '0;
         loc_q  <= '0;
         cnt_q  <= '0;
         cmd_q  <= '0;
         en_q   <= '0;
         sts_q  <= '0;
      end else begin
         if (step) begin
            host_q <= host_q + AW'(4);
            loc_q  <= loc_q + AW'(4);
            cnt_q  <= cnt_last ? '0 : cnt_q - WORD_BYTES;
         end else if (!busy && reg_wr) begin
            if (reg_addr == OFS_HADDR) host_q <= reg_wdata[AW-1:0];
            if (reg_addr == OFS_LADDR) loc_q  <= reg_wdata[AW-1:0];
            if (reg_addr == OFS_COUNT) cnt_q  <= reg_wdata[CW-1:0];
         end
         if (start)     cmd_q <= reg_wdata[1:0];
         else if (stop) cmd_q <= '0;
         if (wr_int) en_q <= reg_wdata[2:0];
         sts_q <= (sts_q & ~clr) | {abrt, corr_err, fin};
      end
   end

   always_comb begin
      unique case (reg_addr)
         OFS_HADDR: reg_rdata = DW'(host_q);
         OFS_LADDR: reg_rdata = DW'(loc_q);
         OFS_COUNT: reg_rdata = DW'(cnt_q);
         OFS_CMD:   reg_rdata = DW'(cmd_q);
         OFS_INT:   reg_rdata = DW'({sts_q, 5'b00000, en_q});
         default:   reg_rdata = '0;
      endcase
   end

   // R10: count is frozen while a move runs, except for word steps
   a_r10_cnt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !step) |=> $stable(cnt_q));
   // R5: every word step strictly lowers the count
   a_r5_cnt_drops: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (cnt_q < $past(cnt_q)));
   // R6: completion is recorded in the status field
   a_r6_done_set: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> sts_q[0]);
   // R9: abort is recorded in the status field
   a_r9_abort_set: assert property (@(posedge clk) disable iff (!rst_n)
      abrt |=> sts_q[2]);
endmodule

// File: rtl/bm_engine.sv
module bm_engine
   import blkmove_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          stop,
   input  logic          abort_err,
   input  logic [1:0]    dir,
   input  logic          cnt_zero,
   input  logic          cnt_last,
   input  logic [AW-1:0] host_base,
   input  logic [AW-1:0] loc_base,
   output logic          loc_req,
   output logic          loc_we,
   output logic [AW-1:0] loc_addr,
   output logic [DW-1:0] loc_wdata,
   input  logic          loc_ack,
   input  logic [DW-1:0] loc_rdata,
   output logic          host_req,
   output logic          host_we,
   output logic [AW-1:0] host_addr,
   output logic [DW-1:0] host_wdata,
   input  logic          host_ack,
   input  logic [DW-1:0] host_rdata,
   output logic          busy,
   output logic          step,
   output logic          fin,
   output logic          abrt
);
   bm_state_e     st_q;
   logic [DW-1:0] buf_q;
   logic          src_loc, src_ack, dst_ack;
   logic [DW-1:0] src_data;

   assign src_loc  = (dir == CMD_L2H);
   assign busy     = (st_q != ST_IDLE);
   assign src_ack  = src_loc ? loc_ack : host_ack;
   assign dst_ack  = src_loc ? host_ack : loc_ack;
   assign src_data = src_loc ? loc_rdata : host_rdata;
   assign loc_req  = ((st_q == ST_FETCH) && src_loc) || ((st_q == ST_STORE) && !src_loc);
   assign host_req = ((st_q == ST_FETCH) && !src_loc) || ((st_q == ST_STORE) && src_loc);
   assign loc_we   = (st_q == ST_STORE);
   assign host_we  = (st_q == ST_STORE);
   assign loc_addr   = loc_base;
   assign host_addr  = host_base;
   assign loc_wdata  = buf_q;
   assign host_wdata = buf_q;
   assign abrt = busy && abort_err;
   assign step = (st_q == ST_STORE) && dst_ack && !abort_err && !stop;
   assign fin  = (step && cnt_last) || (start && cnt_zero);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         buf_q <= '0;
      end else if (abrt || stop) begin
         st_q <= ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE:  if (start && !cnt_zero) st_q <= ST_FETCH;
            ST_FETCH: if (src_ack) begin
                         buf_q <= src_data;
                         st_q  <= ST_STORE;
                      end
            ST_STORE: if (dst_ack) st_q <= cnt_last ? ST_IDLE : ST_FETCH;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   // R13: one port at a time, request held until acknowledged
   a_r13_one_port: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({loc_req, host_req}));
   a_r13_loc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_req && !loc_ack && !abort_err && !stop) |=> loc_req);
   a_r13_host_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && !host_ack && !abort_err && !stop) |=> host_req);
   // R9: abort returns the engine to idle
   a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      abrt |=> !busy);
   // R11: stop returns the engine to idle
   a_r11_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !busy);
endmodule

// File: rtl/blkmove_dma.sv
module blkmove_dma
   import blkmove_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [7:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              loc_req,
   output logic              loc_we,
   output logic [ADDR_W-1:0] loc_addr,
   output logic [DATA_W-1:0] loc_wdata,
   input  logic              loc_ack,
   input  logic [DATA_W-1:0] loc_rdata,
   output logic              host_req,
   output logic              host_we,
   output logic [ADDR_W-1:0] host_addr,
   output logic [DATA_W-1:0] host_wdata,
   input  logic              host_ack,
   input  logic [DATA_W-1:0] host_rdata,
   input  logic              abort_err,
   input  logic              corr_err,
   output logic              irq
);
   generate
      if (DATA_W < 11) begin : g_bad_dw
         $error("DATA_W must hold the interrupt status field");
      end
      if (ADDR_W > DATA_W || CNT_W > DATA_W) begin : g_bad_fit
         $error("address and count must fit in one register word");
      end
      if (CNT_W < 3) begin : g_bad_cw
         $error("CNT_W must count at least one word");
      end
   endgenerate

   logic              busy, step, fin, abrt, start, stop, cnt_last, cnt_zero;
   logic [1:0]        cmd;
   logic [ADDR_W-1:0] host_base, loc_base;

   bm_regs #(.AW(ADDR_W), .DW(DATA_W), .CW(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .step(step),
      .fin(fin), .abrt(abrt), .corr_err(corr_err), .host_base(host_base),
      .loc_base(loc_base), .cmd(cmd), .start(start), .stop(stop),
      .cnt_last(cnt_last), .cnt_zero(cnt_zero), .irq(irq)
   );

   bm_engine #(.AW(ADDR_W), .DW(DATA_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .abort_err(abort_err),
      .dir(cmd), .cnt_zero(cnt_zero), .cnt_last(cnt_last), .host_base(host_base),
      .loc_base(loc_base), .loc_req(loc_req), .loc_we(loc_we), .loc_addr(loc_addr),
      .loc_wdata(loc_wdata), .loc_ack(loc_ack), .loc_rdata(loc_rdata),
      .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
      .busy(busy), .step(step), .fin(fin), .abrt(abrt)
   );

   // R1: no request leaves the block during reset
   a_r1_quiet_reset: assert property (@(posedge clk)
      !rst_n |=> (!loc_req && !host_req));
endmodule

// File: tb/sim_blkmove_dma.sv
module sim_blkmove_dma;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [7:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic loc_req, loc_we, loc_ack = 1'b0, host_req, host_we, host_ack = 1'b0;
   logic [31:0] loc_addr, loc_wdata, loc_rdata = '0, host_addr, host_wdata, host_rdata = '0;
   logic abort_err = 1'b0, corr_err = 1'b0, irq;
   logic [31:0] lmem [256];
   logic [31:0] hmem [256];
   logic req_seen = 1'b0, clr_seen = 1'b0;
   int checks = 0, fails = 0;

   always #10 clk = ~clk;

   blkmove_dma u0 (.*);

   always @(posedge clk) begin
      if (!rst_n) begin
         loc_ack <= 1'b0; host_ack <= 1'b0;
      end else begin
         loc_ack  <= loc_req && !loc_ack;
         host_ack <= host_req && !host_ack;
         if (loc_req && !loc_ack) begin
            if (loc_we) lmem[loc_addr[9:2]] <= loc_wdata;
            loc_rdata <= lmem[loc_addr[9:2]];
         end
         if (host_req && !host_ack) begin
            if (host_we) hmem[host_addr[9:2]] <= host_wdata;
            host_rdata <= hmem[host_addr[9:2]];
         end
      end
      if (clr_seen) req_seen <= 1'b0;
      else if (loc_req || host_req) req_seen <= 1'b1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic clear_seen();
      @(negedge clk); clr_seen = 1'b1;
      @(negedge clk); clr_seen = 1'b0;
   endtask

   task automatic wait_zero(input string req);
      logic [31:0] c;
      for (int i = 0; i < 2000; i++) begin
         rd(8'h68, c);
         if (c == 0) return;
      end
      chk(req, c, 0);
   endtask

   function automatic int words_of(input int cnt);
      return (cnt + 3) / 4;
   endfunction

   task automatic run_move(input int dir, input int si, input int di, input int cnt, input logic [2:0] en);
      int n, bad;
      logic [31:0] v, sent;
      string rq;
      rq = (dir == 1) ? "R3" : "R4";
      n = words_of(cnt);
      for (int i = 0; i < n; i++) begin
         if (dir == 1) begin lmem[si+i] = $urandom; hmem[di+i] = 32'hDEAD0000 | i; end
         else          begin hmem[si+i] = $urandom; lmem[di+i] = 32'hDEAD0000 | i; end
      end
      sent = 32'h5E5E0000 | di;
      if (dir == 1) hmem[di+n] = sent; else lmem[di+n] = sent;
      wr(8'h70, 32'h700 | en);
      wr(8'h60, (dir == 1) ? di*4 : si*4);
      wr(8'h64, (dir == 1) ? si*4 : di*4);
      wr(8'h68, cnt);
      wr(8'h6C, dir);
      wait_zero("R5");
      bad = 0;
      for (int i = 0; i < n; i++) begin
         if (dir == 1) begin if (hmem[di+i] !== lmem[si+i]) bad++; end
         else          begin if (lmem[di+i] !== hmem[si+i]) bad++; end
      end
      chk(rq, bad, 0);
      chk({rq, " sentinel"}, (dir == 1) ? hmem[di+n] : lmem[di+n], sent);
      rd(8'h60, v); chk("R5 host end", v, ((dir == 1) ? di : si)*4 + 4*n);
      rd(8'h64, v); chk("R5 local end", v, ((dir == 1) ? si : di)*4 + 4*n);
      rd(8'h70, v); chk("R6 done", v, 32'h100 | en);
      @(negedge clk); chk("R8 irq", irq, en[0]);
   endtask

   initial begin
      logic [31:0] v, c, h;
      void'($urandom(32'd4711));
      for (int i = 0; i < 256; i++) begin lmem[i] = 0; hmem[i] = 0; end
      repeat (3) @(negedge clk);
      chk("R1 req", {loc_req, host_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int a = 8'h60; a <= 8'h70; a += 4) begin rd(a[7:0], v); chk("R1 reg", v, 0); end
      chk("R1 irq", irq, 0);

      // R2 readback, count truncated to 16 bits
      wr(8'h60, 32'h0000_0120); wr(8'h64, 32'h0000_02A0); wr(8'h68, 32'h0001_FFFC); wr(8'h70, 32'h5);
      rd(8'h60, v); chk("R2 host", v, 32'h120);
      rd(8'h64, v); chk("R2 local", v, 32'h2A0);
      rd(8'h68, v); chk("R2 count", v, 32'hFFFC);
      rd(8'h70, v); chk("R2 int", v, 32'h5);

      // R6 zero count completes with no request
      wr(8'h68, 0); wr(8'h70, 32'h701);
      clear_seen();
      wr(8'h6C, 1);
      repeat (4) @(negedge clk);
      chk("R6 no req", req_seen, 0);
      rd(8'h70, v); chk("R6 zero done", v, 32'h101);
      chk("R8 done irq", irq, 1);

      // R5 directed roundings
      run_move(1, 10, 20, 5, 3'b001);
      run_move(2, 30, 40, 4, 3'b000);
      run_move(1, 0, 250, 16, 3'b101);

      for (int k = 0; k < 24; k++) begin
         run_move(($urandom % 2) + 1, $urandom % 200, $urandom % 200, ($urandom % 80) + 1, 3'($urandom));
      end

      // R12 correctable error and R8 enable
      wr(8'h70, 32'h702);
      @(negedge clk); corr_err = 1'b1; @(negedge clk); corr_err = 1'b0;
      rd(8'h70, v); chk("R12 corr", v, 32'h202);
      chk("R8 corr irq", irq, 1);

      // R9 abort mid-transfer
      wr(8'h70, 32'h500);
      wr(8'h60, 32'h100); wr(8'h64, 32'h200); wr(8'h68, 64); wr(8'h6C, 2);
      repeat (7) @(negedge clk);
      abort_err = 1'b1; @(negedge clk); abort_err = 1'b0;
      repeat (3) @(negedge clk);
      rd(8'h70, v); chk("R9 abort sts", v, 32'h600);
      chk("R8 abort irq", irq, 1);
      rd(8'h6C, v); chk("R9 cmd kept", v, 2);
      rd(8'h68, c); rd(8'h60, h);
      chk("R9 count+progress", c + (h - 32'h100), 64);
      rd(8'h64, v); chk("R9 local progress", v - 32'h200, h - 32'h100);
      chk("R9 stopped early", (c != 0), 1);
      wr(8'h70, 32'h004);
      chk("R8 abort masked", irq, 0);

      // R7 W1C: set done as well, then clear one at a time
      wr(8'h68, 0); wr(8'h6C, 1);
      rd(8'h70, v); chk("R7 all set", v, 32'h704);
      wr(8'h70, 32'h204);
      rd(8'h70, v); chk("R7 clear corr", v, 32'h504);
      wr(8'h70, 32'h104);
      rd(8'h70, v); chk("R7 clear done", v, 32'h404);
      wr(8'h70, 32'h400);
      rd(8'h70, v); chk("R7 clear abort", v, 32'h000);

      // R10 commands and loads ignored while busy
      for (int i = 0; i < 10; i++) begin lmem[100+i] = 32'hA5000000 | i; hmem[60+i] = 0; end
      wr(8'h60, 60*4); wr(8'h64, 100*4); wr(8'h68, 40); wr(8'h6C, 1);
      wr(8'h6C, 2); wr(8'h68, 32'h100); wr(8'h60, 32'h3F0);
      wait_zero("R10");
      rd(8'h6C, v); chk("R10 cmd kept", v, 1);
      rd(8'h60, v); chk("R10 host end", v, 70*4);
      chk("R10 data", hmem[69], 32'hA5000009);

      // R11 stop
      wr(8'h70, 32'h700);
      wr(8'h60, 32'h0); wr(8'h64, 32'h0); wr(8'h68, 200); wr(8'h6C, 2);
      repeat (5) @(negedge clk);
      wr(8'h6C, 0);
      clear_seen();
      rd(8'h68, c);
      repeat (5) @(negedge clk);
      chk("R11 no req", req_seen, 0);
      rd(8'h68, v); chk("R11 frozen", v, c);
      chk("R11 partial", (c != 0 && c != 200), 1);
      rd(8'h6C, v); chk("R11 cmd clr", v, 0);
      rd(8'h70, v); chk("R11 no status", v, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule